// File: doc/BRIEF.md
# Power-down PHY Low-power Handshake

This block works beside a DRAM power-down sequencer. Once the sequencer has dropped CKE to put the memory into precharge power-down, the block may ask the PHY to enter a low-power state. It then decides when that state is left, so that CKE is raised only after the PHY has woken. The handshake is optional and is gated by an enable input. When the enable is clear, or when the PHY does not answer in time, the sequencer carries on without a low-power state.

Entry is triggered by a one-cycle `entry_go` pulse, issued in the same cycle as the CKE-low command. The request to the PHY is held back by the sum of two programmed counts: the controller-side delay and the CKE-low-to-clock-gate time. It carries a wakeup code that is captured at entry. Exit is triggered by a one-cycle `exit_go` pulse. The block withdraws the request and waits for three things: the PHY acknowledge to fall, the wakeup time that the code selects to elapse, and a floor made of the clock-enable delay plus the CKE-high time to elapse. It then pulses `exit_done`. The sequencer holds CKE low until that pulse arrives.

Top module: `pdlp_handshake`

## Requirements
- R1: While reset is held and on the first cycle after it, `phy_lp_req`, `entry_done`, `exit_done` and `lp_ok` are all low.
- R2: An `entry_go` taken while `lp_en` is 0 raises no request. Instead `entry_done` pulses at the next edge with `entry_ok` = 0.
- R3: With `lp_en` = 1, `phy_lp_req` rises exactly N+1 clock edges after the edge that samples `entry_go`, where N = `ctrl_dly` + `ckpde_dly`.
- R4: `phy_lp_wake` equals the `wake_code` sampled with `entry_go` and stays fixed while the request is high, whatever `wake_code` does afterwards.
- R5: If `phy_lp_ack` is sampled high within ACK_WIN edges after the request rose, `entry_done` pulses for one cycle with `entry_ok` = 1. `lp_ok` goes high and the request stays high.
- R6: If no acknowledge is sampled in those ACK_WIN edges, the request falls at the last edge of the window and `entry_done` pulses with `entry_ok` = 0.
- R7: An `exit_go` while no low-power state is held (idle or after a failed attempt) gives an `exit_done` pulse at the next edge, and no request is raised.
- R8: An `exit_go` during the entry delay cancels the attempt. `entry_done` (with `entry_ok` = 0) and `exit_done` both pulse at the next edge, and no request follows.
- R9: An `exit_go` in the low-power state drops the request at the next edge. `exit_done` follows no earlier than max(W, M)+1 edges after the `exit_go` edge, where W = (`wake_code`+1)·WAKE_UNIT and M = `clken_dly` + `ckpdx_dly`.
- R10: `exit_done` waits for `phy_lp_ack` to be sampled low. If the acknowledge falls D edges after the request fell, the pulse comes max(W, M, D)+1 edges after the `exit_go` edge.
- R11: An `exit_go` that arrives while the acknowledge is still awaited is held. If the attempt then succeeds, the exit starts one edge after acceptance. If it fails, `exit_done` pulses together with the failing `entry_done`.
- R12: `lp_ok` falls at the same edge as the `exit_done` that ends a low-power state, and `exit_done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_en | input | 1 | Enables the low-power handshake for power-down |
| wake_code | input | WAKE_W | Wakeup code to send with the request |
| ctrl_dly | input | DLY_W | Controller-side delay count |
| ckpde_dly | input | DLY_W | CKE-low to clock-gate count |
| clken_dly | input | DLY_W | DRAM clock-enable delay count |
| ckpdx_dly | input | DLY_W | Clock-restart to CKE-high count |
| entry_go | input | 1 | One-cycle pulse: CKE-low command issued |
| exit_go | input | 1 | One-cycle pulse: sequencer wants to leave power-down |
| phy_lp_ack | input | 1 | Acknowledge from the PHY |
| phy_lp_req | output | 1 | Low-power request to the PHY |
| phy_lp_wake | output | WAKE_W | Wakeup code presented with the request |
| entry_done | output | 1 | One-cycle pulse: the entry attempt has ended |
| entry_ok | output | 1 | Result of the last attempt, valid with `entry_done` |
| lp_ok | output | 1 | The PHY is held in the low-power state |
| exit_done | output | 1 | One-cycle pulse: CKE may be raised |

## Verification
The assertions assume a well-behaved sequencer and PHY. `entry_go` and `exit_go` are never high in the same cycle. The four delay counts stay constant from a trigger until the matching done pulse. The PHY raises its acknowledge only while the request is high and drops it only after the request has fallen. The bench keeps to these rules: it pulses each trigger alone and holds every count from trigger to completion. Its PHY model answers at a chosen latency after the request rises and releases a chosen number of cycles after the request falls. Both latencies are drawn from $urandom, so some attempts time out and some releases arrive after the timers have expired.

// File: rtl/pdlp_pkg.sv
package pdlp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DELAY = 3'd1,
      ST_REQ   = 3'd2,
      ST_LP    = 3'd3,
      ST_WAKE  = 3'd4
   } pdlp_st_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pdlp_downcnt.sv
module pdlp_downcnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   generate
      if (CW < 1) begin : g_bad_cw
         $error("pdlp_downcnt: CW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

   a_cnt_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(zero)) |-> zero);

endmodule

// File: rtl/pdlp_wake_decode.sv
module pdlp_wake_decode #(
   parameter int WAKE_W    = 4,
   parameter int WCYC_W    = 8,
   parameter int WAKE_UNIT = 4,
   parameter bit WAKE_EXP  = 1'b0
) (
   input  logic [WAKE_W-1:0] code,
   output logic [WCYC_W-1:0] cycles
);

   localparam int PW = WAKE_W + WCYC_W + 1;

   generate
      if (WAKE_UNIT < 1) begin : g_bad_unit
         $error("pdlp_wake_decode: WAKE_UNIT must be at least 1");
      end
      if (WCYC_W < 2 || WCYC_W > 30) begin : g_bad_wcyc
         $error("pdlp_wake_decode: WCYC_W out of range");
      end

      if (WAKE_EXP) begin : g_exp
         always_comb begin
            if (int'(code) >= WCYC_W) begin
               cycles = '1;
            end else begin
               cycles = WCYC_W'(1) << code;
            end
         end
      end else begin : g_lin
         logic [PW-1:0] prod;
         always_comb begin
            prod = (PW'(code) + PW'(1)) * PW'(WAKE_UNIT);
            if (prod > PW'({WCYC_W{1'b1}})) begin
               cycles = '1;
            end else begin
               cycles = prod[WCYC_W-1:0];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pdlp_handshake.sv
module pdlp_handshake
   import pdlp_pkg::*;
#(
   parameter int DLY_W     = 6,
   parameter int WAKE_W    = 4,
   parameter int WCYC_W    = 8,
   parameter int WAKE_UNIT = 4,
   parameter bit WAKE_EXP  = 1'b0,
   parameter int ACK_WIN   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_en,
   input  logic [WAKE_W-1:0] wake_code,
   input  logic [DLY_W-1:0]  ctrl_dly,
   input  logic [DLY_W-1:0]  ckpde_dly,
   input  logic [DLY_W-1:0]  clken_dly,
   input  logic [DLY_W-1:0]  ckpdx_dly,
   input  logic              entry_go,
   input  logic              exit_go,
   input  logic              phy_lp_ack,
   output logic              phy_lp_req,
   output logic [WAKE_W-1:0] phy_lp_wake,
   output logic              entry_done,
   output logic              entry_ok,
   output logic              lp_ok,
   output logic              exit_done
);

   localparam int SUM_W = DLY_W + 1;
   localparam int WIN_W = $clog2(ACK_WIN + 1);
   localparam int CHK_W = imax(SUM_W, WCYC_W) + 2;

   generate
      if (DLY_W < 1) begin : g_bad_dly
         $error("pdlp_handshake: DLY_W must be at least 1");
      end
      if (ACK_WIN < 1) begin : g_bad_win
         $error("pdlp_handshake: ACK_WIN must be at least 1");
      end
      if (WAKE_W < 1) begin : g_bad_wake
         $error("pdlp_handshake: WAKE_W must be at least 1");
      end
   endgenerate

   pdlp_st_e          st_q;
   logic              req_q;
   logic [WAKE_W-1:0] wake_q;
   logic              lpok_q;
   logic              ent_done_q;
   logic              ent_ok_q;
   logic              ex_done_q;
   logic              pend_q;

   logic [SUM_W-1:0]  ent_sum;
   logic [SUM_W-1:0]  min_sum;
   logic [WCYC_W-1:0] wake_cyc;
   logic              ld_ent;
   logic              ld_win;
   logic              ld_exit;
   logic              ent_zero;
   logic              win_zero;
   logic              wake_zero;
   logic              min_zero;
   logic              exit_req;

   assign ent_sum  = {1'b0, ctrl_dly}  + {1'b0, ckpde_dly};
   assign min_sum  = {1'b0, clken_dly} + {1'b0, ckpdx_dly};
   assign exit_req = exit_go | pend_q;

   assign ld_ent  = (st_q == ST_IDLE)  && entry_go && !exit_go && lp_en;
   assign ld_win  = (st_q == ST_DELAY) && !exit_go && ent_zero;
   assign ld_exit = (st_q == ST_LP)    && exit_req;

   pdlp_wake_decode #(
      .WAKE_W    (WAKE_W),
      .WCYC_W    (WCYC_W),
      .WAKE_UNIT (WAKE_UNIT),
      .WAKE_EXP  (WAKE_EXP)
   ) u_wdec (
      .code   (wake_q),
      .cycles (wake_cyc)
   );

   pdlp_downcnt #(.CW(SUM_W)) u_ent_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_ent),
      .load_val (ent_sum),
      .zero     (ent_zero)
   );

   pdlp_downcnt #(.CW(WIN_W)) u_win_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_win),
      .load_val (WIN_W'(ACK_WIN - 1)),
      .zero     (win_zero)
   );

   pdlp_downcnt #(.CW(WCYC_W)) u_wake_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_exit),
      .load_val (wake_cyc),
      .zero     (wake_zero)
   );

   pdlp_downcnt #(.CW(SUM_W)) u_min_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_exit),
      .load_val (min_sum),
      .zero     (min_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         req_q      <= 1'b0;
         wake_q     <= '0;
         lpok_q     <= 1'b0;
         ent_done_q <= 1'b0;
         ent_ok_q   <= 1'b0;
         ex_done_q  <= 1'b0;
         pend_q     <= 1'b0;
      end else begin
         ent_done_q <= 1'b0;
         ex_done_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (exit_go) begin
                  ex_done_q <= 1'b1;
               end else if (entry_go) begin
                  if (lp_en) begin
                     st_q   <= ST_DELAY;
                     wake_q <= wake_code;
                  end else begin
                     ent_done_q <= 1'b1;
                     ent_ok_q   <= 1'b0;
                  end
               end
            end
            ST_DELAY: begin
               if (exit_go) begin
                  st_q       <= ST_IDLE;
                  ent_done_q <= 1'b1;
                  ent_ok_q   <= 1'b0;
                  ex_done_q  <= 1'b1;
               end else if (ent_zero) begin
                  st_q  <= ST_REQ;
                  req_q <= 1'b1;
               end
            end
            ST_REQ: begin
               if (phy_lp_ack) begin
                  st_q       <= ST_LP;
                  ent_done_q <= 1'b1;
                  ent_ok_q   <= 1'b1;
                  lpok_q     <= 1'b1;
                  pend_q     <= exit_req;
               end else if (win_zero) begin
                  st_q       <= ST_IDLE;
                  req_q      <= 1'b0;
                  ent_done_q <= 1'b1;
                  ent_ok_q   <= 1'b0;
                  ex_done_q  <= exit_req;
                  pend_q     <= 1'b0;
               end else begin
                  pend_q <= exit_req;
               end
            end
            ST_LP: begin
               if (exit_req) begin
                  st_q   <= ST_WAKE;
                  req_q  <= 1'b0;
                  pend_q <= 1'b0;
               end
            end
            ST_WAKE: begin
               if (!phy_lp_ack && wake_zero && min_zero) begin
                  st_q      <= ST_IDLE;
                  lpok_q    <= 1'b0;
                  ex_done_q <= 1'b1;
               end
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign phy_lp_req  = req_q;
   assign phy_lp_wake = wake_q;
   assign entry_done  = ent_done_q;
   assign entry_ok    = ent_ok_q;
   assign lp_ok       = lpok_q;
   assign exit_done   = ex_done_q;

   // ---------------- checker state: cycles since each trigger ----------
   logic [CHK_W-1:0] since_ent_q;
   logic [CHK_W-1:0] since_ex_q;
   logic [SUM_W-1:0] ent_sum_lat_q;
   logic [SUM_W-1:0] min_sum_lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_ent_q   <= '0;
         since_ex_q    <= '0;
         ent_sum_lat_q <= '0;
         min_sum_lat_q <= '0;
      end else begin
         if (ld_ent) begin
            since_ent_q   <= '0;
            ent_sum_lat_q <= ent_sum;
         end else if (since_ent_q != '1) begin
            since_ent_q <= since_ent_q + 1'b1;
         end
         if (ld_exit) begin
            since_ex_q    <= '0;
            min_sum_lat_q <= min_sum;
         end else if (since_ex_q != '1) begin
            since_ex_q <= since_ex_q + 1'b1;
         end
      end
   end

   // R1: quiet outputs right after reset
   a_r1_reset_quiet : assert property (@(posedge clk)
      $rose(rst_n) |-> (!phy_lp_req && !entry_done && !exit_done && !lp_ok));

   // R2: disabled entry gives a failed result, no request
   a_r2_disabled_no_req : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && entry_go && !exit_go && !lp_en)
         |=> (!phy_lp_req && entry_done && !entry_ok));

   // R3: request never rises before the programmed entry delay
   a_r3_entry_delay : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_lp_req) |-> (since_ent_q > CHK_W'(ent_sum_lat_q)));

   // R4: wake field held while the request is up
   a_r4_wake_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (phy_lp_req && $past(phy_lp_req)) |-> $stable(phy_lp_wake));

   // R5: a successful entry leaves the request up
   a_r5_ok_keeps_req : assert property (@(posedge clk) disable iff (!rst_n)
      (entry_done && entry_ok) |-> (phy_lp_req && lp_ok));

   // R6: a failed entry leaves no request
   a_r6_fail_no_req : assert property (@(posedge clk) disable iff (!rst_n)
      (entry_done && !entry_ok) |-> (!phy_lp_req && !lp_ok));

   // R9: exit never completes before the minimum floor
   a_r9_exit_floor : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lp_ok) |-> (since_ex_q > CHK_W'(min_sum_lat_q)));

   // R10: completion only after the acknowledge was seen low
   a_r10_ack_low : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lp_ok) |-> ($past(!phy_lp_ack) && !phy_lp_req));

   // R12: lp_ok falls together with exit_done; exit_done is one cycle
   a_r12_okfall_done : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lp_ok) |-> exit_done);
   a_r12_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      exit_done |=> !exit_done);

endmodule

// File: tb/pdlp_handshake_tb.sv
`timescale 1ns/1ps
module pdlp_handshake_tb;

   localparam int DLY_W     = 6;
   localparam int WAKE_W    = 4;
   localparam int WCYC_W    = 8;
   localparam int WAKE_UNIT = 4;
   localparam int ACK_WIN   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lp_en = 1'b0;
   logic [WAKE_W-1:0] wake_code = '0;
   logic [DLY_W-1:0]  ctrl_dly = '0;
   logic [DLY_W-1:0]  ckpde_dly = '0;
   logic [DLY_W-1:0]  clken_dly = '0;
   logic [DLY_W-1:0]  ckpdx_dly = '0;
   logic              entry_go = 1'b0;
   logic              exit_go = 1'b0;
   logic              phy_lp_ack = 1'b0;
   logic              phy_lp_req;
   logic [WAKE_W-1:0] phy_lp_wake;
   logic              entry_done;
   logic              entry_ok;
   logic              lp_ok;
   logic              exit_done;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   pdlp_handshake #(
      .DLY_W     (DLY_W),
      .WAKE_W    (WAKE_W),
      .WCYC_W    (WCYC_W),
      .WAKE_UNIT (WAKE_UNIT),
      .WAKE_EXP  (1'b0),
      .ACK_WIN   (ACK_WIN)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .lp_en       (lp_en),
      .wake_code   (wake_code),
      .ctrl_dly    (ctrl_dly),
      .ckpde_dly   (ckpde_dly),
      .clken_dly   (clken_dly),
      .ckpdx_dly   (ckpdx_dly),
      .entry_go    (entry_go),
      .exit_go     (exit_go),
      .phy_lp_ack  (phy_lp_ack),
      .phy_lp_req  (phy_lp_req),
      .phy_lp_wake (phy_lp_wake),
      .entry_done  (entry_done),
      .entry_ok    (entry_ok),
      .lp_ok       (lp_ok),
      .exit_done   (exit_done)
   );

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int wake_cycles(input int code);
      return (code + 1) * WAKE_UNIT;
   endfunction

   function automatic int exp_req_ticks(input int c, input int p);
      return c + p + 2;
   endfunction

   function automatic int exp_exit_ticks(input int w, input int m, input int d);
      return max3(w, m, d) + 2;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Starts an entry attempt; ack_lat >= ACK_WIN means the PHY stays silent.
   task automatic run_entry(input int c, input int p, input int code,
                            input int ack_lat, output bit ok);
      int n;
      ctrl_dly  = DLY_W'(c);
      ckpde_dly = DLY_W'(p);
      wake_code = WAKE_W'(code);
      lp_en     = 1'b1;
      entry_go  = 1'b1;
      tick();
      entry_go = 1'b0;
      n = 1;
      while (!phy_lp_req && n < 500) begin
         tick();
         n++;
      end
      chk("R3 request delay ticks", n, exp_req_ticks(c, p));
      wake_code = WAKE_W'(~code);
      chk("R4 wake field held", int'(phy_lp_wake), code);
      if (ack_lat < ACK_WIN) begin
         repeat (ack_lat) tick();
         phy_lp_ack = 1'b1;
         tick();
         chk("R5 entry_done", int'(entry_done), 1);
         chk("R5 entry_ok", int'(entry_ok), 1);
         chk("R5 lp_ok and req", int'(lp_ok & phy_lp_req), 1);
         tick();
         chk("R5 entry_done one cycle", int'(entry_done), 0);
         ok = 1'b1;
      end else begin
         repeat (ACK_WIN - 1) tick();
         chk("R6 req held inside window", int'(phy_lp_req), 1);
         tick();
         chk("R6 req dropped", int'(phy_lp_req), 0);
         chk("R6 entry_done fail", int'(entry_done & ~entry_ok), 1);
         ok = 1'b0;
      end
   endtask

   // Exit from the low-power state; the PHY drops ack d ticks after req falls.
   task automatic run_exit_lp(input int cken, input int cpdx, input int code, input int d);
      int n;
      clken_dly = DLY_W'(cken);
      ckpdx_dly = DLY_W'(cpdx);
      exit_go   = 1'b1;
      tick();
      exit_go = 1'b0;
      n = 1;
      chk("R9 req falls after exit_go", int'(phy_lp_req), 0);
      while (!exit_done && n < 2000) begin
         if (n == 1 + d) phy_lp_ack = 1'b0;
         tick();
         n++;
      end
      phy_lp_ack = 1'b0;
      chk("R10 exit_done ticks", n, exp_exit_ticks(wake_cycles(code), cken + cpdx, d));
      chk("R12 lp_ok cleared with exit_done", int'(lp_ok), 0);
      tick();
      chk("R12 exit_done one cycle", int'(exit_done), 0);
   endtask

   task automatic run_exit_idle();
      exit_go = 1'b1;
      tick();
      exit_go = 1'b0;
      chk("R7 exit_done without low-power", int'(exit_done), 1);
      chk("R7 no request", int'(phy_lp_req), 0);
      tick();
   endtask

   initial begin : watchdog
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      bit ok;
      int n;
      void'($urandom(32'd1234));

      tick();
      chk("R1 req low in reset", int'(phy_lp_req), 0);
      chk("R1 done low in reset", int'(entry_done | exit_done | lp_ok), 0);
      tick();
      rst_n = 1'b1;
      tick();
      chk("R1 outputs quiet after reset", int'(phy_lp_req | entry_done | exit_done | lp_ok), 0);

      // R2: disabled handshake
      lp_en    = 1'b0;
      entry_go = 1'b1;
      tick();
      entry_go = 1'b0;
      chk("R2 entry_done fail when disabled", int'(entry_done & ~entry_ok), 1);
      n = 0;
      repeat (12) begin
         tick();
         n += int'(phy_lp_req);
      end
      chk("R2 no request when disabled", n, 0);
      run_exit_idle();

      // R8: abort during delay
      ctrl_dly  = DLY_W'(3);
      ckpde_dly = DLY_W'(2);
      lp_en     = 1'b1;
      entry_go  = 1'b1;
      tick();
      entry_go = 1'b0;
      exit_go  = 1'b1;
      tick();
      exit_go = 1'b0;
      chk("R8 abort entry_done fail", int'(entry_done & ~entry_ok), 1);
      chk("R8 abort exit_done", int'(exit_done), 1);
      n = 0;
      repeat (12) begin
         tick();
         n += int'(phy_lp_req);
      end
      chk("R8 no request after abort", n, 0);

      // Directed: zero delays, immediate ack, ack held long (R10)
      run_entry(0, 0, 0, 0, ok);
      run_exit_lp(0, 0, 0, 40);
      // Directed: minimum floor dominates the wakeup time (R9)
      run_entry(2, 1, 1, 3, ok);
      run_exit_lp(9, 7, 1, 0);
      // Directed: ack at last window cycle, then timeout
      run_entry(1, 1, 2, ACK_WIN - 1, ok);
      run_exit_lp(1, 1, 2, 2);
      run_entry(4, 0, 3, ACK_WIN, ok);
      run_exit_idle();

      // R11: exit requested while ack is awaited, then accepted
      ctrl_dly = '0; ckpde_dly = '0; clken_dly = DLY_W'(5); ckpdx_dly = DLY_W'(6);
      wake_code = WAKE_W'(1);
      entry_go = 1'b1;
      tick();
      entry_go = 1'b0;
      while (!phy_lp_req) tick();
      exit_go = 1'b1;
      tick();
      exit_go    = 1'b0;
      phy_lp_ack = 1'b1;
      tick();
      chk("R11 accepted despite pending exit", int'(entry_done & entry_ok), 1);
      tick();
      chk("R11 req falls one edge after accept", int'(phy_lp_req), 0);
      phy_lp_ack = 1'b0;
      n = 0;
      while (!exit_done && n < 2000) begin
         tick();
         n++;
      end
      chk("R11 deferred exit ticks", n, max3(wake_cycles(1), 11, 0) + 1);
      tick();

      // R11: exit pending, attempt times out
      wake_code = WAKE_W'(0);
      entry_go = 1'b1;
      tick();
      entry_go = 1'b0;
      while (!phy_lp_req) tick();
      exit_go = 1'b1;
      tick();
      exit_go = 1'b0;
      repeat (ACK_WIN - 1) tick();
      chk("R11 failed attempt with pending exit", int'(entry_done & ~entry_ok & exit_done), 1);
      tick();

      // Constrained random mix
      for (int i = 0; i < 40; i++) begin
         int c, p, code, lat, ck, px, d;
         c    = int'($urandom_range(0, 5));
         p    = int'($urandom_range(0, 5));
         code = int'($urandom_range(0, 7));
         lat  = int'($urandom_range(0, ACK_WIN + 2));
         ck   = int'($urandom_range(0, 20));
         px   = int'($urandom_range(0, 20));
         d    = int'($urandom_range(0, 45));
         run_entry(c, p, code, lat, ok);
         if (ok) run_exit_lp(ck, px, code, d);
         else run_exit_idle();
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule